// File: doc/BRIEF.md
# Flag-Setting Integer Adder with Operand Shaping

This block is the integer add/subtract and bitwise-logic stage of a scalar datapath. Each cycle it takes two 64-bit source operands, an operation code, a 32/64-bit width select and a flag-update enable. It returns a registered result and a registered four-bit condition flag set. The flags are N (negative), Z (zero), C (carry) and V (signed overflow). The second operand is first shaped, inside the same cycle, by one of two paths. The shift path applies a logical left, logical right or arithmetic right shift by an immediate amount. The extend path zero- or sign-extends a byte, halfword, word or doubleword and then shifts it left by up to four places.

The flags change only when the caller requests it. This lets pure computations pass between a flag-setting operation and the branch that consumes its flags. The carry variants of add and subtract read the held C flag. A chain of operations can therefore build sums and differences of any width, one limb per cycle. On subtraction, C means "no borrow". A compare is simply a flag-setting subtract whose result the consumer ignores, and a bit test is a flag-setting AND whose result the consumer ignores.

The block has no state machine. Its only state is the result register and the flag register, both written on the rising clock edge and cleared by a synchronous reset.

Top module: `flagged_adder`

## Requirements
- R1: When `set_flags` is 0, `nzcv` keeps its previous value at the next edge, while `result` still updates.
- R2: Code 0 adds and code 1 subtracts (`A + B'` and `A - B'`, where B' is the shaped second operand), both modulo 2^W. W is 64, or 32 when `is32` is 1.
- R3: Code 2 computes `A + B' + C` and code 3 computes `A - B' - (1 - C)`. C is the flag value held before the edge, so consecutive operations chain carry and borrow across limbs.
- R4: On a flag update for codes 0 to 3, C is the unsigned carry out of bit W-1. For subtraction this means C = 1 exactly when no borrow occurs. V = 1 exactly when the exact signed result does not fit in W bits.
- R5: Codes 4 to 9 select the logic operations AND, OR, XOR, A & ~B', A | ~B' and A ^ ~B', in that order. A flag-setting logic operation sets N and Z from the result, forces C to 0 and leaves V unchanged. Codes 10 to 15 behave as code 0.
- R6: On any flag update, N equals result bit W-1 and Z is 1 exactly when the W-bit result is zero. The flag vector is ordered {N,Z,C,V} from bit 3 down to bit 0.
- R7: When `use_ext` is 0, B' is the second operand shifted by `shift_amt`, taken modulo W. `shift_kind` selects the shift: 0 for logical left, 1 for logical right, 2 for arithmetic right, and 3 behaves as 0.
- R8: When `use_ext` is 1, the extend field `ext_sel[1:0]` picks bits [7:0], [15:0], [31:0] or all 64 bits of the second operand. `ext_sel[2]` selects sign extension (1) or zero extension (0). The extended value is shifted left by `ext_shl`, and values 5 to 7 shift by 4.
- R9: In 32-bit mode, only the low 32 bits of each operand take part, the flags come from bits [31:0], and `result[63:32]` is 0.
- R10: Inputs present at a rising edge appear on `result` and `nzcv` just after that edge. A synchronous reset (`rst` high at an edge) clears both `result` and `nzcv` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | First source operand |
| op_b | input | 64 | Second source operand, before shaping |
| is32 | input | 1 | 1 selects 32-bit operation |
| opsel | input | 4 | Operation code (0 ADD, 1 SUB, 2 ADC, 3 SBC, 4 AND, 5 OR, 6 XOR, 7 AND-NOT, 8 OR-NOT, 9 XNOR) |
| set_flags | input | 1 | 1 writes the flag register this cycle |
| use_ext | input | 1 | 0 selects the shift path, 1 selects the extend path |
| shift_kind | input | 2 | Shift type on the shift path |
| shift_amt | input | 6 | Shift distance on the shift path |
| ext_sel | input | 3 | Extend field width and signedness |
| ext_shl | input | 3 | Left shift after extension |
| result | output | 64 | Registered result |
| nzcv | output | 4 | Registered flags {N,Z,C,V} |

## Verification
Two functions can meet in the same cycle. A carry-using operation reads the held C flag at the same edge where it may write a new one. The bench provokes this with long runs of back-to-back operations whose codes, widths and flag enables are mixed. A flag-holding cycle can also separate a flag-setting operation from its consumer. Every cycle is judged against a bench-side flag model that advances only when `set_flags` is high. The expected carry, borrow and overflow come from exact wide-integer arithmetic and range tests, not from bit-level adder logic.

// File: rtl/fa_pkg.sv
package fa_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_ADC  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_ANDN = 4'd7,
        OP_ORN  = 4'd8,
        OP_XNOR = 4'd9
    } op_e;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ALT = 2'd3
    } shk_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;
endpackage

// File: rtl/fa_opnd_shaper.sv
module fa_opnd_shaper #(
    parameter int XW      = 64,
    parameter int EXT_MAX = 4
) (
    input  logic [XW-1:0]          b_in,
    input  logic                   is32,
    input  logic                   use_ext,
    input  logic [1:0]             shift_kind,
    input  logic [$clog2(XW)-1:0]  shift_amt,
    input  logic [2:0]             ext_sel,
    input  logic [2:0]             ext_shl,
    output logic [XW-1:0]          b_out
);
    import fa_pkg::*;

    localparam int HW   = XW / 2;
    localparam int SW   = $clog2(XW);
    localparam int NEXT = 3;

    logic [XW-1:0] zx [NEXT+1];
    logic [XW-1:0] sx [NEXT+1];

    // narrow extend candidates: 8, 16, 32 bits; last slot is the full width
    for (genvar gi = 0; gi < NEXT; gi++) begin : g_ext
        localparam int FW = 8 << gi;
        assign zx[gi] = {{(XW-FW){1'b0}}, b_in[FW-1:0]};
        assign sx[gi] = {{(XW-FW){b_in[FW-1]}}, b_in[FW-1:0]};
    end
    assign zx[NEXT] = b_in;
    assign sx[NEXT] = b_in;

    logic [XW-1:0]   sh_full;
    logic [HW-1:0]   sh_half;
    logic [SW-2:0]   amt_half;
    logic [XW-1:0]   sh_path;
    logic [XW-1:0]   ext_val;
    logic [2:0]      ext_amt;
    logic [XW-1:0]   ext_path;

    assign amt_half = shift_amt[SW-2:0];

    always_comb begin
        unique case (shk_e'(shift_kind))
            SK_LSR:  sh_full = b_in >> shift_amt;
            SK_ASR:  sh_full = XW'($signed(b_in) >>> shift_amt);
            default: sh_full = b_in << shift_amt;
        endcase
    end

    always_comb begin
        unique case (shk_e'(shift_kind))
            SK_LSR:  sh_half = b_in[HW-1:0] >> amt_half;
            SK_ASR:  sh_half = HW'($signed(b_in[HW-1:0]) >>> amt_half);
            default: sh_half = b_in[HW-1:0] << amt_half;
        endcase
    end

    assign sh_path = is32 ? {{(XW-HW){1'b0}}, sh_half} : sh_full;

    always_comb begin
        ext_val = ext_sel[2] ? sx[ext_sel[1:0]] : zx[ext_sel[1:0]];
        ext_amt = (int'(ext_shl) > EXT_MAX) ? 3'(EXT_MAX) : ext_shl;
        ext_path = ext_val << ext_amt;
        if (is32) begin
            ext_path[XW-1:HW] = '0;
        end
    end

    assign b_out = use_ext ? ext_path : sh_path;
endmodule

// File: rtl/fa_core.sv
module fa_core #(
    parameter int XW = 64
) (
    input  logic [XW-1:0] a,
    input  logic [XW-1:0] bq,
    input  logic          is32,
    input  logic [3:0]    opsel,
    input  logic          c_held,
    output logic [XW-1:0] res,
    output fa_pkg::flags_t arith_flags,
    output logic          is_logic
);
    import fa_pkg::*;

    localparam int HW = XW / 2;

    op_e            op;
    logic           invert_b;
    logic           cin;
    logic [XW-1:0]  bx;
    logic [XW:0]    sum_full;
    logic [HW:0]    sum_half;
    logic [XW-1:0]  arith_res;
    logic [XW-1:0]  logic_res;
    logic [XW-1:0]  pre;
    logic           msb_a;
    logic           msb_b;
    logic           msb_r;
    logic           cout;

    assign op = op_e'(opsel);

    always_comb begin
        invert_b = 1'b0;
        cin      = 1'b0;
        is_logic = 1'b0;
        unique case (op)
            OP_SUB:  begin invert_b = 1'b1; cin = 1'b1; end
            OP_ADC:  cin = c_held;
            OP_SBC:  begin invert_b = 1'b1; cin = c_held; end
            OP_AND, OP_OR, OP_XOR, OP_ANDN, OP_ORN, OP_XNOR: is_logic = 1'b1;
            default: ;
        endcase
    end

    assign bx       = invert_b ? ~bq : bq;
    assign sum_full = {1'b0, a} + {1'b0, bx} + {{XW{1'b0}}, cin};
    assign sum_half = {1'b0, a[HW-1:0]} + {1'b0, bx[HW-1:0]} + {{HW{1'b0}}, cin};

    assign arith_res = is32 ? {{(XW-HW){1'b0}}, sum_half[HW-1:0]} : sum_full[XW-1:0];
    assign cout      = is32 ? sum_half[HW] : sum_full[XW];

    always_comb begin
        unique case (op)
            OP_AND:  logic_res = a & bq;
            OP_OR:   logic_res = a | bq;
            OP_XOR:  logic_res = a ^ bq;
            OP_ANDN: logic_res = a & ~bq;
            OP_ORN:  logic_res = a | ~bq;
            OP_XNOR: logic_res = a ^ ~bq;
            default: logic_res = '0;
        endcase
    end

    always_comb begin
        pre = is_logic ? logic_res : arith_res;
        if (is32) begin
            pre[XW-1:HW] = '0;
        end
    end
    assign res = pre;

    assign msb_a = is32 ? a[HW-1]   : a[XW-1];
    assign msb_b = is32 ? bx[HW-1]  : bx[XW-1];
    assign msb_r = is32 ? pre[HW-1] : pre[XW-1];

    assign arith_flags.n = msb_r;
    assign arith_flags.z = is32 ? (pre[HW-1:0] == '0) : (pre == '0);
    assign arith_flags.c = cout;
    assign arith_flags.v = (msb_a == msb_b) && (msb_r != msb_a);
endmodule

// File: rtl/flagged_adder.sv
module flagged_adder #(
    parameter int XW      = 64,
    parameter int EXT_MAX = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [XW-1:0]         op_a,
    input  logic [XW-1:0]         op_b,
    input  logic                  is32,
    input  logic [3:0]            opsel,
    input  logic                  set_flags,
    input  logic                  use_ext,
    input  logic [1:0]            shift_kind,
    input  logic [$clog2(XW)-1:0] shift_amt,
    input  logic [2:0]            ext_sel,
    input  logic [2:0]            ext_shl,
    output logic [XW-1:0]         result,
    output logic [3:0]            nzcv
);
    import fa_pkg::*;

    localparam int HW = XW / 2;

    logic [XW-1:0] b_shaped;
    logic [XW-1:0] res_d;
    flags_t        arith_fl;
    flags_t        flags_q;
    flags_t        flags_d;
    logic          logic_op;
    logic [XW-1:0] res_q;

    fa_opnd_shaper #(.XW(XW), .EXT_MAX(EXT_MAX)) u_shape (
        .b_in       (op_b),
        .is32       (is32),
        .use_ext    (use_ext),
        .shift_kind (shift_kind),
        .shift_amt  (shift_amt),
        .ext_sel    (ext_sel),
        .ext_shl    (ext_shl),
        .b_out      (b_shaped)
    );

    fa_core #(.XW(XW)) u_core (
        .a           (op_a),
        .bq          (b_shaped),
        .is32        (is32),
        .opsel       (opsel),
        .c_held      (flags_q.c),
        .res         (res_d),
        .arith_flags (arith_fl),
        .is_logic    (logic_op)
    );

    always_comb begin
        flags_d = arith_fl;
        if (logic_op) begin
            flags_d.c = 1'b0;
            flags_d.v = flags_q.v;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            flags_q <= '0;
        end else begin
            res_q <= res_d;
            if (set_flags) begin
                flags_q <= flags_d;
            end
        end
    end

    assign result = res_q;
    assign nzcv   = flags_q;

    // R1: flags hold when no update is requested
    a_r1_flags_hold: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> nzcv == $past(nzcv));

    // R5: flag-setting logic op clears C
    a_r5_logic_c_zero: assert property (@(posedge clk) disable iff (rst)
        (set_flags && logic_op) |=> !nzcv[1]);

    // R5: flag-setting logic op keeps V
    a_r5_logic_v_keep: assert property (@(posedge clk) disable iff (rst)
        (set_flags && logic_op) |=> nzcv[0] == $past(nzcv[0]));

    // R6: Z agrees with the registered result
    a_r6_z_tracks: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> nzcv[2] == (result == '0));

    // R6: N agrees with the top bit of the active width
    a_r6_n_tracks: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> nzcv[3] == ($past(is32) ? result[HW-1] : result[XW-1]));

    // R9: 32-bit results leave the upper half clear
    a_r9_upper_zero: assert property (@(posedge clk) disable iff (rst)
        is32 |=> result[XW-1:HW] == '0);
endmodule

// File: tb/sim_flagged_adder.sv
module sim_flagged_adder;
    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] op_a, op_b;
    logic        is32;
    logic [3:0]  opsel;
    logic        set_flags;
    logic        use_ext;
    logic [1:0]  shift_kind;
    logic [5:0]  shift_amt;
    logic [2:0]  ext_sel;
    logic [2:0]  ext_shl;
    logic [63:0] result;
    logic [3:0]  nzcv;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0]  m_nzcv;
    logic [63:0] m_res;

    always #5 clk = ~clk;

    flagged_adder u0 (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .is32(is32),
        .opsel(opsel), .set_flags(set_flags), .use_ext(use_ext),
        .shift_kind(shift_kind), .shift_amt(shift_amt), .ext_sel(ext_sel),
        .ext_shl(ext_shl), .result(result), .nzcv(nzcv)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mdl_b(input logic [63:0] b, input logic w32,
        input logic ue, input logic [1:0] sk, input logic [5:0] sa,
        input logic [2:0] es, input logic [2:0] eh);
        logic [63:0] v;
        logic [31:0] x;
        logic [63:0] msk;
        int fw;
        int sh;
        if (!ue) begin
            if (w32) begin
                x = b[31:0];
                case (sk)
                    2'd1: x = x >> sa[4:0];
                    2'd2: x = $signed(x) >>> sa[4:0];
                    default: x = x << sa[4:0];
                endcase
                return {32'b0, x};
            end
            case (sk)
                2'd1: v = b >> sa;
                2'd2: v = $signed(b) >>> sa;
                default: v = b << sa;
            endcase
            return v;
        end
        fw  = 8 << es[1:0];
        msk = (fw == 64) ? '1 : ((64'h1 << fw) - 64'h1);
        v   = b & msk;
        if (es[2] && fw < 64 && b[fw-1]) v = v | ~msk;
        sh  = (eh > 3'd4) ? 4 : int'(eh);
        v   = v << sh;
        if (w32) v[63:32] = '0;
        return v;
    endfunction

    task automatic step(input logic [63:0] a, input logic [63:0] b, input logic w32,
        input logic [3:0] op, input logic sf, input logic ue, input logic [1:0] sk,
        input logic [5:0] sa, input logic [2:0] es, input logic [2:0] eh);
        logic [63:0] bb, aa, r;
        logic [65:0] ua, ub, ur;
        logic signed [65:0] sa6, sb6, sr, hi;
        logic cin, brw, c, v, nn, zz;
        string tg;
        int w;
        @(negedge clk);
        op_a = a; op_b = b; is32 = w32; opsel = op; set_flags = sf;
        use_ext = ue; shift_kind = sk; shift_amt = sa; ext_sel = es; ext_shl = eh;
        w  = w32 ? 32 : 64;
        bb = mdl_b(b, w32, ue, sk, sa, es, eh);
        aa = w32 ? {32'b0, a[31:0]} : a;
        bb = w32 ? {32'b0, bb[31:0]} : bb;
        ua = {2'b0, aa};
        ub = {2'b0, bb};
        sa6 = w32 ? {{34{aa[31]}}, aa[31:0]} : {{2{aa[63]}}, aa};
        sb6 = w32 ? {{34{bb[31]}}, bb[31:0]} : {{2{bb[63]}}, bb};
        c = m_nzcv[1]; v = m_nzcv[0];
        tg = "R5";
        if (op <= 4'd3 || op >= 4'd10) begin
            tg = (op == 4'd2 || op == 4'd3) ? "R3" : "R2";
            if (op == 4'd1 || op == 4'd3) begin
                brw = (op == 4'd1) ? 1'b0 : !m_nzcv[1];
                ur = ua - ub - {65'b0, brw};
                sr = sa6 - sb6 - $signed({65'b0, brw});
                c  = (ua >= ub + {65'b0, brw});
            end else begin
                cin = (op == 4'd2) ? m_nzcv[1] : 1'b0;
                ur = ua + ub + {65'b0, cin};
                sr = sa6 + sb6 + $signed({65'b0, cin});
                c  = ((ur >> w) != 66'd0);
            end
            r  = ur[63:0];
            hi = sr >>> (w - 1);
            v  = (hi != 66'sd0) && (hi != -66'sd1);
        end else begin
            case (op)
                4'd4: r = aa & bb;
                4'd5: r = aa | bb;
                4'd6: r = aa ^ bb;
                4'd7: r = aa & ~bb;
                4'd8: r = aa | ~bb;
                default: r = aa ^ ~bb;
            endcase
            c = 1'b0;
        end
        if (w32) r[63:32] = '0;
        nn = r[w-1];
        zz = (r == 64'd0);
        m_res = r;
        if (sf) m_nzcv = {nn, zz, c, v};
        @(posedge clk);
        #1;
        chk({tg, " result"}, result, m_res);
        chk(sf ? ((tg == "R5") ? "R5 flags" : "R4 flags") : "R1 flags held",
            {60'b0, nzcv}, {60'b0, m_nzcv});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        m_nzcv = 4'b0;
        chk("R10 reset result", result, 64'd0);
        chk("R10 reset flags", {60'b0, nzcv}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    logic [63:0] corner [8];

    initial begin
        #2_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        corner[0] = 64'h0;
        corner[1] = 64'h1;
        corner[2] = 64'h7FFF_FFFF_FFFF_FFFF;
        corner[3] = 64'h8000_0000_0000_0000;
        corner[4] = 64'hFFFF_FFFF_FFFF_FFFF;
        corner[5] = 64'h0000_0000_7FFF_FFFF;
        corner[6] = 64'h0000_0000_8000_0000;
        corner[7] = 64'h1234_5678_9ABC_DEF0;
        rst = 1'b1; op_a = '0; op_b = '0; is32 = 0; opsel = 0; set_flags = 0;
        use_ext = 0; shift_kind = 0; shift_amt = 0; ext_sel = 0; ext_shl = 0;
        m_nzcv = 4'b0;
        repeat (3) @(posedge clk);
        do_reset();

        // near-exhaustive sweep over codes, widths and corner operands
        for (int op = 0; op < 10; op++)
            for (int wm = 0; wm < 2; wm++)
                for (int ai = 0; ai < 8; ai++)
                    for (int bi = 0; bi < 8; bi++)
                        step(corner[ai], corner[bi], wm[0], op[3:0], ((ai + bi) % 3) != 0,
                             1'b0, 2'd0, 6'd0, 3'd0, 3'd0);

        // R6: equal operands subtract to zero, no borrow
        step(64'h55, 64'h55, 1'b0, 4'd1, 1'b1, 1'b0, 2'd0, 6'd0, 3'd0, 3'd0);
        chk("R6 zero subtract flags", {60'b0, nzcv}, 64'h6);
        // R1: no update keeps the flags, result still moves
        step(64'h3, 64'h4, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 6'd0, 3'd0, 3'd0);
        chk("R1 result moves", result, 64'h7);
        chk("R1 flags unchanged", {60'b0, nzcv}, 64'h6);
        // R7: arithmetic vs logical right shift
        step(64'h0, 64'h8000_0000_0000_0000, 1'b0, 4'd0, 1'b0, 1'b0, 2'd2, 6'd4, 3'd0, 3'd0);
        chk("R7 asr", result, 64'hF800_0000_0000_0000);
        step(64'h0, 64'h8000_0000_0000_0000, 1'b0, 4'd0, 1'b0, 1'b0, 2'd1, 6'd4, 3'd0, 3'd0);
        chk("R7 lsr", result, 64'h0800_0000_0000_0000);
        // R8: sign-extend byte, shift code 7 saturates to 4
        step(64'h0, 64'h0000_0000_0000_0080, 1'b0, 4'd0, 1'b0, 1'b1, 2'd0, 6'd0, 3'd4, 3'd7);
        chk("R8 sxtb shl sat", result, 64'hFFFF_FFFF_FFFF_F800);
        step(64'h0, 64'hFFFF_FFFF_FFFF_FF80, 1'b0, 4'd0, 1'b0, 1'b1, 2'd1, 6'd0, 3'd1, 3'd2);
        chk("R8 uxth shl2", result, 64'h0000_0000_0003_FE00);
        // R9: 32-bit wrap to zero with carry
        step(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, 4'd0, 1'b1, 1'b0, 2'd0, 6'd0, 3'd0, 3'd0);
        chk("R9 upper zero", result, 64'h0);
        chk("R9 flags from low word", {60'b0, nzcv}, 64'h6);
        // R3: 128-bit chain, low limb carries into high limb
        step(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 4'd0, 1'b1, 1'b0, 2'd0, 6'd0, 3'd0, 3'd0);
        step(64'h10, 64'h20, 1'b0, 4'd2, 1'b1, 1'b0, 2'd0, 6'd0, 3'd0, 3'd0);
        chk("R3 adc high limb", result, 64'h31);
        step(64'h0, 64'h1, 1'b0, 4'd1, 1'b1, 1'b0, 2'd0, 6'd0, 3'd0, 3'd0);
        step(64'h10, 64'h5, 1'b0, 4'd3, 1'b1, 1'b0, 2'd0, 6'd0, 3'd0, 3'd0);
        chk("R3 sbc high limb", result, 64'hA);

        // mixed back-to-back traffic
        for (int i = 0; i < 3000; i++) begin
            step({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom),
                 4'($urandom_range(0, 15)), 1'($urandom), 1'($urandom),
                 2'($urandom), 6'($urandom), 3'($urandom), 3'($urandom));
            if (i == 1500) do_reset();
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule